// File: doc/BRIEF.md
# Shadowed Configuration Register Bank

This block holds the run-time parameters of an iterative block decoder and serves them to the datapath. A small processor bus (16-bit write data, 16-bit read data, 4-bit address, active-low select, read/write strobe) reaches nine registers. These are four block lengths, one packed word of four coding-rate codes, a signalling-standard bit, upper and lower bounds on the half-iteration count, and an early-stop threshold.

The length and rate fields are double-buffered. Bus writes to them fill a pending copy, and a single-cycle commit pulse moves every pending copy into the live copy on the same edge. The new group can therefore be loaded while the decoder keeps working with the old one. A separate single-cycle advance pulse steps the active set pointer to the next of the four sets, so the length and rate seen by the datapath change on a block boundary with no bus traffic. Readback always shows the live copy.

Top module: `dec_cfg_regbank`

## Requirements
- R1: After reset, every block length reads 3856 (0x0F10) and the rate word reads 0x55, so each set carries rate code 01. The standard bit reads 1, the maximum half-iteration count reads 14, the minimum reads 0 and the threshold reads 15. The active set index is 0, and act_len, act_rate and act_std show set 0's length, its rate and the standard bit.
- R2: A bus access is a write when bus_cs_n is 0 and bus_rd_wr_n is 0. Address 4 (standard bit, bit 0), address 6 (maximum count, bits [4:0]), address 7 (minimum count, bits [4:0]) and address 8 (threshold, bits [3:0]) take written data at the clock edge of the write. These values show on their output ports and in readback at once. Data bits above a field's width are dropped and read back as 0.
- R3: A write to address 0..3 (block length of set 0..3, bits [14:0]) or to address 5 (rate codes, set k in bits [2k+1:2k], with 00 = 1/2, 01 = 1/3, 10 = 1/4, 11 = spare) changes neither the readback nor act_len/act_rate until a commit.
- R4: A one-cycle commit_pulse copies all four pending lengths and the pending rate word into the live registers on the same edge.
- R5: A one-cycle advance_pulse moves act_set to the next set, and act_len/act_rate follow from the next cycle. Set 3 wraps to set 0. Without the pulse the index holds.
- R6: Writes to addresses 9..15 change no register, and reads of them return 0.
- R7: With bus_cs_n high, no register is written whatever the other bus inputs do.
- R8: Driving rst_n low restores all R1 values and clears bus_rdata at once, without waiting for a clock edge.
- R9: A write to a pending register in the same cycle as a commit stores the new value in the pending copy only. The commit moves the value held before that edge, and the new value goes live at the next commit.
- R10: A read (bus_cs_n 0, bus_rd_wr_n 1) places the addressed register on bus_rdata at the clock edge of the access. bus_rdata holds its value in cycles with no read, including write cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wdata | input | 16 | Bus write data |
| bus_addr | input | 4 | Register address |
| bus_cs_n | input | 1 | Bus select, active low |
| bus_rd_wr_n | input | 1 | 1 = read, 0 = write |
| bus_rdata | output | 16 | Registered read data |
| commit_pulse | input | 1 | Move pending lengths and rates to live |
| advance_pulse | input | 1 | Step active set to the next one |
| act_len | output | 15 | Live block length of the active set |
| act_rate | output | 2 | Live rate code of the active set |
| act_std | output | 1 | Standard select bit |
| act_set | output | 2 | Index of the active set |
| max_half | output | 5 | Maximum half-iteration count |
| min_half | output | 5 | Minimum half-iteration count |
| et_thresh | output | 4 | Early-stop threshold |

## Verification
The bench builds the bank with its default parameters: four sets, 15-bit lengths, 2-bit rate codes and a 4-bit address. This leaves seven unmapped addresses to probe and makes the set pointer wrap after four advances. A length value with bit 15 set and a rate word that uses all four codes, including the spare one, show field truncation and the per-set slicing on the active outputs. A write placed in the commit cycle and a reset dropped between clock edges reach the ordering and asynchronous cases.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
   localparam int CFG_DATA_W = 16;
   localparam int CFG_ADDR_W = 4;
   localparam int CFG_SETS   = 4;
   localparam int CFG_LEN_W  = 15;
   localparam int CFG_RATE_W = 2;
   localparam int CFG_HALF_W = 5;
   localparam int CFG_THR_W  = 4;

   typedef enum logic [1:0] {
      RATE_HALF    = 2'b00,
      RATE_THIRD   = 2'b01,
      RATE_QUARTER = 2'b10,
      RATE_SPARE   = 2'b11
   } rate_code_e;

   localparam int CFG_LEN_RST  = 3856;
   localparam int CFG_RATE_RST = int'(RATE_THIRD);
   localparam int CFG_STD_RST  = 1;
   localparam int CFG_MAXH_RST = 14;
   localparam int CFG_MINH_RST = 0;
   localparam int CFG_THR_RST  = 15;
endpackage

// File: rtl/cfg_bus_decode.sv
module cfg_bus_decode #(
   parameter int ADDR_W   = 4,
   parameter int NUM_REGS = 9
) (
   input  logic                cs_n,
   input  logic                rd_wr_n,
   input  logic [ADDR_W-1:0]   addr,
   output logic                rd_en,
   output logic [NUM_REGS-1:0] wr_sel
);
   logic wr_en;

   assign wr_en = !cs_n && !rd_wr_n;
   assign rd_en = !cs_n && rd_wr_n;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
      assign wr_sel[i] = wr_en && (addr == ADDR_W'(i));
   end
endmodule

// File: rtl/cfg_set_bank.sv
module cfg_set_bank #(
   parameter int LEN_W    = 15,
   parameter int RATE_W   = 2,
   parameter int LEN_RST  = 3856,
   parameter int RATE_RST = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              len_we,
   input  logic              rate_we,
   input  logic [LEN_W-1:0]  len_wd,
   input  logic [RATE_W-1:0] rate_wd,
   input  logic              commit,
   output logic [LEN_W-1:0]  live_len,
   output logic [RATE_W-1:0] live_rate
);
   logic [LEN_W-1:0]  pend_len;
   logic [RATE_W-1:0] pend_rate;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_len  <= LEN_W'(LEN_RST);
         pend_rate <= RATE_W'(RATE_RST);
         live_len  <= LEN_W'(LEN_RST);
         live_rate <= RATE_W'(RATE_RST);
      end else begin
         if (len_we)  pend_len  <= len_wd;
         if (rate_we) pend_rate <= rate_wd;
         if (commit) begin
            live_len  <= pend_len;
            live_rate <= pend_rate;
         end
      end
   end
endmodule

// File: rtl/cfg_set_select.sv
module cfg_set_select #(
   parameter int NUM_SETS = 4,
   localparam int SEL_W   = $clog2(NUM_SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             advance,
   output logic [SEL_W-1:0] sel
);
   localparam logic [SEL_W-1:0] LAST = SEL_W'(NUM_SETS - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sel <= '0;
      else if (advance)
         sel <= (sel == LAST) ? '0 : sel + 1'b1;
   end
endmodule

// File: rtl/dec_cfg_regbank.sv
module dec_cfg_regbank
   import cfg_pkg::*;
#(
   parameter int DATA_W   = CFG_DATA_W,
   parameter int ADDR_W   = CFG_ADDR_W,
   parameter int NUM_SETS = CFG_SETS,
   parameter int LEN_W    = CFG_LEN_W,
   parameter int RATE_W   = CFG_RATE_W,
   parameter int HALF_W   = CFG_HALF_W,
   parameter int THR_W    = CFG_THR_W,
   parameter int LEN_RST  = CFG_LEN_RST,
   parameter int RATE_RST = CFG_RATE_RST,
   parameter int STD_RST  = CFG_STD_RST,
   parameter int MAXH_RST = CFG_MAXH_RST,
   parameter int MINH_RST = CFG_MINH_RST,
   parameter int THR_RST  = CFG_THR_RST
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [DATA_W-1:0]           bus_wdata,
   input  logic [ADDR_W-1:0]           bus_addr,
   input  logic                        bus_cs_n,
   input  logic                        bus_rd_wr_n,
   output logic [DATA_W-1:0]           bus_rdata,
   input  logic                        commit_pulse,
   input  logic                        advance_pulse,
   output logic [LEN_W-1:0]            act_len,
   output logic [RATE_W-1:0]           act_rate,
   output logic                        act_std,
   output logic [$clog2(NUM_SETS)-1:0] act_set,
   output logic [HALF_W-1:0]           max_half,
   output logic [HALF_W-1:0]           min_half,
   output logic [THR_W-1:0]            et_thresh
);
   localparam int SEL_W     = $clog2(NUM_SETS);
   localparam int PACK_W    = NUM_SETS * RATE_W;
   localparam int STD_ADDR  = NUM_SETS;
   localparam int RATE_ADDR = NUM_SETS + 1;
   localparam int MAXH_ADDR = NUM_SETS + 2;
   localparam int MINH_ADDR = NUM_SETS + 3;
   localparam int THR_ADDR  = NUM_SETS + 4;
   localparam int NUM_REGS  = NUM_SETS + 5;

   // elaboration-time parameter checks
   if (NUM_SETS < 2 || (1 << SEL_W) != NUM_SETS) begin : g_bad_sets
      $error("NUM_SETS must be a power of two, at least 2");
   end
   if (NUM_REGS > (1 << ADDR_W)) begin : g_bad_addr
      $error("address space too small for the register map");
   end
   if (LEN_W >= DATA_W || PACK_W > DATA_W) begin : g_bad_width
      $error("length or packed rate field exceeds bus width");
   end
   if (HALF_W > DATA_W || THR_W > DATA_W) begin : g_bad_small
      $error("counter or threshold field exceeds bus width");
   end

   logic                rd_en;
   logic [NUM_REGS-1:0] wr_sel;
   logic [LEN_W-1:0]    live_len  [NUM_SETS];
   logic [RATE_W-1:0]   live_rate [NUM_SETS];
   logic [PACK_W-1:0]   rate_pack;
   logic [DATA_W-1:0]   rd_mux;
   logic                std_q;
   logic [HALF_W-1:0]   maxh_q, minh_q;
   logic [THR_W-1:0]    thr_q;
   logic [DATA_W-1:0]   rdata_q;
   logic                unused_wdata_hi;

   assign unused_wdata_hi = ^bus_wdata[DATA_W-1:LEN_W];

   cfg_bus_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
      .cs_n    (bus_cs_n),
      .rd_wr_n (bus_rd_wr_n),
      .addr    (bus_addr),
      .rd_en   (rd_en),
      .wr_sel  (wr_sel)
   );

   for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
      cfg_set_bank #(
         .LEN_W(LEN_W), .RATE_W(RATE_W),
         .LEN_RST(LEN_RST), .RATE_RST(RATE_RST)
      ) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .len_we    (wr_sel[s]),
         .rate_we   (wr_sel[RATE_ADDR]),
         .len_wd    (bus_wdata[LEN_W-1:0]),
         .rate_wd   (bus_wdata[s*RATE_W +: RATE_W]),
         .commit    (commit_pulse),
         .live_len  (live_len[s]),
         .live_rate (live_rate[s])
      );
      assign rate_pack[s*RATE_W +: RATE_W] = live_rate[s];
   end

   cfg_set_select #(.NUM_SETS(NUM_SETS)) u_sel (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (advance_pulse),
      .sel     (act_set)
   );

   // unshadowed registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         std_q  <= 1'(STD_RST);
         maxh_q <= HALF_W'(MAXH_RST);
         minh_q <= HALF_W'(MINH_RST);
         thr_q  <= THR_W'(THR_RST);
      end else begin
         if (wr_sel[STD_ADDR])  std_q  <= bus_wdata[0];
         if (wr_sel[MAXH_ADDR]) maxh_q <= bus_wdata[HALF_W-1:0];
         if (wr_sel[MINH_ADDR]) minh_q <= bus_wdata[HALF_W-1:0];
         if (wr_sel[THR_ADDR])  thr_q  <= bus_wdata[THR_W-1:0];
      end
   end

   // readback multiplexer, live copies only
   always_comb begin
      rd_mux = '0;
      for (int i = 0; i < NUM_SETS; i++) begin
         if (bus_addr == ADDR_W'(i)) rd_mux[LEN_W-1:0] = live_len[i];
      end
      if (bus_addr == ADDR_W'(STD_ADDR))  rd_mux[0]          = std_q;
      if (bus_addr == ADDR_W'(RATE_ADDR)) rd_mux[PACK_W-1:0] = rate_pack;
      if (bus_addr == ADDR_W'(MAXH_ADDR)) rd_mux[HALF_W-1:0] = maxh_q;
      if (bus_addr == ADDR_W'(MINH_ADDR)) rd_mux[HALF_W-1:0] = minh_q;
      if (bus_addr == ADDR_W'(THR_ADDR))  rd_mux[THR_W-1:0]  = thr_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata_q <= '0;
      else if (rd_en)
         rdata_q <= rd_mux;
   end

   assign bus_rdata = rdata_q;
   assign act_len   = live_len[act_set];
   assign act_rate  = live_rate[act_set];
   assign act_std   = std_q;
   assign max_half  = maxh_q;
   assign min_half  = minh_q;
   assign et_thresh = thr_q;
endmodule

// File: rtl/cfg_regbank_chk.sv
module cfg_regbank_chk #(
   parameter int DATA_W   = 16,
   parameter int ADDR_W   = 4,
   parameter int NUM_SETS = 4,
   parameter int LEN_W    = 15,
   parameter int RATE_W   = 2,
   parameter int HALF_W   = 5,
   parameter int THR_W    = 4
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [ADDR_W-1:0]           bus_addr,
   input logic                        bus_cs_n,
   input logic                        bus_rd_wr_n,
   input logic [DATA_W-1:0]           bus_rdata,
   input logic                        commit_pulse,
   input logic                        advance_pulse,
   input logic [LEN_W-1:0]            act_len,
   input logic [RATE_W-1:0]           act_rate,
   input logic [$clog2(NUM_SETS)-1:0] act_set,
   input logic [HALF_W-1:0]           max_half,
   input logic [HALF_W-1:0]           min_half,
   input logic [THR_W-1:0]            et_thresh
);
   localparam int SEL_W    = $clog2(NUM_SETS);
   localparam int NUM_REGS = NUM_SETS + 5;

   logic is_read, is_write, hi_addr;
   assign is_read  = !bus_cs_n && bus_rd_wr_n;
   assign is_write = !bus_cs_n && !bus_rd_wr_n;
   assign hi_addr  = {1'b0, bus_addr} >= (ADDR_W + 1)'(NUM_REGS);

   // R5: advance moves to the next set, wrapping at the last
   a_r5_advance_next: assert property (@(posedge clk) disable iff (!rst_n)
      advance_pulse |=> act_set == (($past(act_set) == SEL_W'(NUM_SETS - 1))
                                    ? '0 : $past(act_set) + 1'b1));

   // R5: index holds without advance
   a_r5_set_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !advance_pulse |=> $stable(act_set));

   // R3: active length and rate move only on commit or advance
   a_r3_active_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!commit_pulse && !advance_pulse) |=> ($stable(act_len) && $stable(act_rate)));

   // R6: unmapped addresses read as zero
   a_r6_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (is_read && hi_addr) |=> bus_rdata == '0);

   // R10: read data holds outside read cycles
   a_r10_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !is_read |=> $stable(bus_rdata));

   // R2: unshadowed registers change only on a bus write
   a_r2_plain_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !is_write |=> ($stable(max_half) && $stable(min_half) && $stable(et_thresh)));
endmodule

bind dec_cfg_regbank cfg_regbank_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_SETS(NUM_SETS), .LEN_W(LEN_W),
   .RATE_W(RATE_W), .HALF_W(HALF_W), .THR_W(THR_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .bus_addr      (bus_addr),
   .bus_cs_n      (bus_cs_n),
   .bus_rd_wr_n   (bus_rd_wr_n),
   .bus_rdata     (bus_rdata),
   .commit_pulse  (commit_pulse),
   .advance_pulse (advance_pulse),
   .act_len       (act_len),
   .act_rate      (act_rate),
   .act_set       (act_set),
   .max_half      (max_half),
   .min_half      (min_half),
   .et_thresh     (et_thresh)
);

// File: tb/dec_cfg_regbank_tb_top.sv
`timescale 1ns/1ps
module dec_cfg_regbank_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [3:0]  bus_addr = '0;
   logic        bus_cs_n = 1'b1;
   logic        bus_rd_wr_n = 1'b1;
   logic [15:0] bus_rdata;
   logic        commit_pulse = 1'b0;
   logic        advance_pulse = 1'b0;
   logic [14:0] act_len;
   logic [1:0]  act_rate;
   logic        act_std;
   logic [1:0]  act_set;
   logic [4:0]  max_half, min_half;
   logic [3:0]  et_thresh;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   dec_cfg_regbank dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wdata(bus_wdata), .bus_addr(bus_addr),
      .bus_cs_n(bus_cs_n), .bus_rd_wr_n(bus_rd_wr_n), .bus_rdata(bus_rdata),
      .commit_pulse(commit_pulse), .advance_pulse(advance_pulse),
      .act_len(act_len), .act_rate(act_rate), .act_std(act_std),
      .act_set(act_set), .max_half(max_half), .min_half(min_half),
      .et_thresh(et_thresh)
   );

   task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, got, exp);
      end
   endtask

   task automatic bus_wr(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_cs_n = 1'b0; bus_rd_wr_n = 1'b0; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_cs_n = 1'b1; bus_rd_wr_n = 1'b1;
   endtask

   task automatic bus_rd(input logic [3:0] a, output logic [15:0] v);
      @(negedge clk);
      bus_cs_n = 1'b0; bus_rd_wr_n = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_cs_n = 1'b1;
      v = bus_rdata;
   endtask

   task automatic pulse_commit();
      @(negedge clk); commit_pulse = 1'b1;
      @(negedge clk); commit_pulse = 1'b0;
   endtask

   task automatic pulse_advance();
      @(negedge clk); advance_pulse = 1'b1;
      @(negedge clk); advance_pulse = 1'b0;
   endtask

   // vector fields: {req[3:0], op[1:0], addr[3:0], data[15:0], exp[15:0]}
   // op: 0 write, 1 read and compare, 2 commit then compare act_len, 3 advance then compare act_len
   localparam int NV = 37;
   localparam logic [41:0] VEC [NV] = '{
      {4'd1, 2'd1, 4'd0, 16'h0000, 16'h0F10},  // R1 length default
      {4'd1, 2'd1, 4'd4, 16'h0000, 16'h0001},  // R1 standard default
      {4'd1, 2'd1, 4'd5, 16'h0000, 16'h0055},  // R1 rate word default
      {4'd1, 2'd1, 4'd6, 16'h0000, 16'h000E},  // R1 max default
      {4'd1, 2'd1, 4'd7, 16'h0000, 16'h0000},  // R1 min default
      {4'd1, 2'd1, 4'd8, 16'h0000, 16'h000F},  // R1 threshold default
      {4'd6, 2'd1, 4'd9, 16'h0000, 16'h0000},  // R6 unmapped read
      {4'd2, 2'd0, 4'd6, 16'hFFFF, 16'h0000},
      {4'd2, 2'd1, 4'd6, 16'h0000, 16'h001F},  // R2 truncation
      {4'd2, 2'd0, 4'd7, 16'h0003, 16'h0000},
      {4'd2, 2'd1, 4'd7, 16'h0000, 16'h0003},  // R2
      {4'd2, 2'd0, 4'd8, 16'h00A7, 16'h0000},
      {4'd2, 2'd1, 4'd8, 16'h0000, 16'h0007},  // R2 truncation
      {4'd2, 2'd0, 4'd4, 16'h0000, 16'h0000},
      {4'd2, 2'd1, 4'd4, 16'h0000, 16'h0000},  // R2
      {4'd3, 2'd0, 4'd0, 16'h8064, 16'h0000},
      {4'd3, 2'd1, 4'd0, 16'h0000, 16'h0F10},  // R3 readback still live copy
      {4'd3, 2'd0, 4'd1, 16'h00C8, 16'h0000},
      {4'd3, 2'd0, 4'd2, 16'h012C, 16'h0000},
      {4'd3, 2'd0, 4'd3, 16'h7FFF, 16'h0000},
      {4'd3, 2'd0, 4'd5, 16'h00E4, 16'h0000},
      {4'd3, 2'd1, 4'd5, 16'h0000, 16'h0055},  // R3
      {4'd4, 2'd2, 4'd0, 16'h0000, 16'h0064},  // R4 commit, set 0 active
      {4'd4, 2'd1, 4'd0, 16'h0000, 16'h0064},  // R4
      {4'd4, 2'd1, 4'd1, 16'h0000, 16'h00C8},  // R4
      {4'd4, 2'd1, 4'd2, 16'h0000, 16'h012C},  // R4
      {4'd4, 2'd1, 4'd3, 16'h0000, 16'h7FFF},  // R4
      {4'd4, 2'd1, 4'd5, 16'h0000, 16'h00E4},  // R4
      {4'd5, 2'd3, 4'd0, 16'h0000, 16'h00C8},  // R5 set 1
      {4'd5, 2'd3, 4'd0, 16'h0000, 16'h012C},  // R5 set 2
      {4'd5, 2'd3, 4'd0, 16'h0000, 16'h7FFF},  // R5 set 3
      {4'd5, 2'd3, 4'd0, 16'h0000, 16'h0064},  // R5 wrap to set 0
      {4'd6, 2'd0, 4'd9, 16'h1234, 16'h0000},
      {4'd6, 2'd0, 4'd15, 16'hFFFF, 16'h0000},
      {4'd6, 2'd1, 4'd15, 16'h0000, 16'h0000}, // R6
      {4'd6, 2'd1, 4'd8, 16'h0000, 16'h0007},  // R6 no side effect
      {4'd6, 2'd1, 4'd9, 16'h0000, 16'h0000}   // R6
   };

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 active outputs after reset
      check("R1 act_len", 16'(act_len), 16'h0F10);
      check("R1 act_rate", 16'(act_rate), 16'h0001);
      check("R1 act_std", 16'(act_std), 16'h0001);
      check("R1 act_set", 16'(act_set), 16'h0000);
      check("R1 max_half", 16'(max_half), 16'd14);
      check("R1 min_half", 16'(min_half), 16'd0);
      check("R1 et_thresh", 16'(et_thresh), 16'd15);
      check("R1 rdata", bus_rdata, 16'h0000);

      for (int i = 0; i < NV; i++) begin
         logic [3:0]  rq;
         logic [1:0]  op;
         logic [3:0]  a;
         logic [15:0] d, e;
         string       tg;
         {rq, op, a, d, e} = VEC[i];
         tg = $sformatf("R%0d vec%0d", rq, i);
         case (op)
            2'd0: bus_wr(a, d);
            2'd1: begin bus_rd(a, v); check(tg, v, e); end
            2'd2: begin pulse_commit(); check(tg, 16'(act_len), e); end
            default: begin pulse_advance(); check(tg, 16'(act_len), e); end
         endcase
      end

      // R2 port view of plain registers
      check("R2 max_half port", 16'(max_half), 16'h001F);
      check("R2 act_std port", 16'(act_std), 16'h0000);

      // R3 pending write leaves active length alone
      bus_wr(4'd0, 16'h0011);
      check("R3 act_len unchanged", 16'(act_len), 16'h0064);
      bus_rd(4'd0, v);
      check("R3 readback unchanged", v, 16'h0064);

      // R9 write in commit cycle
      @(negedge clk);
      bus_cs_n = 1'b0; bus_rd_wr_n = 1'b0; bus_addr = 4'd1; bus_wdata = 16'h0022;
      commit_pulse = 1'b1;
      @(negedge clk);
      bus_cs_n = 1'b1; bus_rd_wr_n = 1'b1; commit_pulse = 1'b0;
      bus_rd(4'd1, v);
      check("R9 old pending committed", v, 16'h00C8);
      bus_rd(4'd0, v);
      check("R9 set0 committed", v, 16'h0011);
      pulse_commit();
      bus_rd(4'd1, v);
      check("R9 new value at next commit", v, 16'h0022);

      // R7 deselected write
      @(negedge clk);
      bus_cs_n = 1'b1; bus_rd_wr_n = 1'b0; bus_addr = 4'd6; bus_wdata = 16'h0005;
      @(negedge clk);
      bus_rd_wr_n = 1'b1;
      bus_rd(4'd6, v);
      check("R7 deselected write ignored", v, 16'h001F);

      // R5 rate slicing per set (rate word 0xE4)
      pulse_advance();
      check("R5 set index", 16'(act_set), 16'h0001);
      check("R5 rate set1", 16'(act_rate), 16'h0001);
      check("R5 len set1", 16'(act_len), 16'h0022);
      pulse_advance();
      check("R5 rate set2", 16'(act_rate), 16'h0002);
      pulse_advance();
      check("R5 rate set3", 16'(act_rate), 16'h0003);
      @(negedge clk);
      check("R5 index holds", 16'(act_set), 16'h0003);

      // R10 read data timing and hold
      bus_rd(4'd8, v);
      check("R10 read data", v, 16'h0007);
      repeat (2) @(negedge clk);
      check("R10 hold idle", bus_rdata, 16'h0007);
      bus_wr(4'd8, 16'h0009);
      check("R10 hold over write", bus_rdata, 16'h0007);
      check("R2 threshold port", 16'(et_thresh), 16'h0009);

      // R8 asynchronous reset between edges
      @(negedge clk);
      #1 rst_n = 1'b0;
      #0.5;
      check("R8 act_len", 16'(act_len), 16'h0F10);
      check("R8 act_set", 16'(act_set), 16'h0000);
      check("R8 rdata", bus_rdata, 16'h0000);
      check("R8 threshold", 16'(et_thresh), 16'h000F);
      @(negedge clk);
      rst_n = 1'b1;
      bus_rd(4'd7, v);
      check("R8 min readback", v, 16'h0000);
      bus_rd(4'd1, v);
      check("R8 length readback", v, 16'h0F10);
      bus_rd(4'd5, v);
      check("R8 rate readback", v, 16'h0055);

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule